// File: doc/BRIEF.md
# Edge-Interrupt GPIO Bank Controller

This block is a memory-mapped controller for one bank of up to 32 general-purpose lines. The lines form four 8-bit ports, A to D; line `n` belongs to port `n/8` as pin `n%8`. Software reaches it over a plain 32-bit register bus with an address, a write strobe, write data and combinational read data. Through that bus it sets line direction, output data, a per-line peripheral-function select and a 2-bit edge mode per line. It reads back line levels and pending edge events from a write-one-to-clear status register.

Every pin input passes through a two-flop synchroniser. A third flop holds the value one clock earlier, and comparing the two detects rising and falling edges. The 2-bit mode field of each line both selects the edge and masks the line: mode 0 means no event is ever taken. Pending events drive one combined interrupt. A window of per-CPU enable words gives each CPU its own interrupt output.

A parameter picks one of two packings of the ports into the bus word. In the reversed layout, line `n` is at bit `n`. In the normal layout the bytes are in big-endian order, and the two mode words hold port pairs in swapped halves.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset, the function-select, direction, data and both mode registers read 0 with all pins low. Status reads 0, `irq` and every `cpu_irq` bit are low, and each per-CPU enable word reads all ones for the implemented lines.
- R2: Byte addresses are: function select 0x00, direction 0x08, data 0x0C, status 0x10, mode word 0 at 0x14, mode word 1 at 0x18, and the enable word of CPU `c` at 0x20+4*c. Any other address reads 0 and a write to it has no effect.
- R3: In the 1-bit registers (function, direction, data, status, CPU enables), line `8p+k` sits at bus bit `8p+k` in the reversed layout and at bus bit `8*(3-p)+k` in the normal layout.
- R4: The mode field of line `8p+k` sits at bit `2*(8p+k)` of the 64-bit pair {word 1, word 0} in the reversed layout. In the normal layout it sits at bit `2*(8*(p xor 1)+k)`.
- R5: Mode values are 0 = off, 1 = falling edge, 2 = rising edge, 3 = both edges. A matching edge on `pin_in` sets the line's status bit at the third rising clock edge after the pin changes. No status bit is ever set without a matching edge.
- R6: Writing 1 to a status bit clears it at the next clock edge, and writing 0 leaves it unchanged.
- R7: When an edge event and a clearing write hit the same status bit in the same cycle, the bit stays set.
- R8: `pin_oe` and `pin_out` carry the direction and data registers in line order. A data read returns the data register bit for an output line and the synchronised pin for an input line. Edges are detected whatever the direction.
- R9: Lines at or above `NUM_LINES` read 0 in every register, ignore writes, and never set status or raise an interrupt.
- R10: `irq` is the OR of all status bits. `cpu_irq[c]` is the OR of status AND the enable word of CPU `c`.
- R11: `pin_func` carries the function-select register in line order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_we | input | 1 | Write strobe, taken on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| pin_in | input | 32 | Asynchronous pin levels, bit `n` is line `n` |
| pin_out | output | 32 | Output data per line |
| pin_oe | output | 32 | Output enable per line (1 = output) |
| pin_func | output | 32 | Peripheral-function select per line |
| irq | output | 1 | Combined interrupt |
| cpu_irq | output | NUM_CPUS | Per-CPU interrupt |

## Verification
The assertions assume that `pin_in` holds low through reset, so no edge is seen as the synchroniser leaves reset. They also assume that a clearing write and an edge event arrive only through the ports, in the cycles the bus strobe and synchroniser define. The stimulus changes pins only at falling clock edges and holds each pin pattern for four clocks before the next change, so every edge is seen exactly once. Bus writes are driven one at a time between falling edges. One directed case lines a clearing write up on the exact cycle in which an edge event lands. Two instances share the stimulus: one in the normal layout with 28 lines, and one in the reversed layout with all 32 lines.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int MAX_LINES    = 32;
    localparam int PORT_W       = 8;

    // register byte offsets
    localparam int OFS_FUNC     = 'h00;
    localparam int OFS_DIR      = 'h08;
    localparam int OFS_DATA     = 'h0C;
    localparam int OFS_STAT     = 'h10;
    localparam int OFS_MODE_LO  = 'h14;
    localparam int OFS_MODE_HI  = 'h18;
    localparam int OFS_CPU_BASE = 'h20;
    localparam int CPU_STRIDE   = 4;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'd0,
        MODE_FALL = 2'd1,
        MODE_RISE = 2'd2,
        MODE_BOTH = 2'd3
    } edge_mode_e;

    // line order <-> bus order for 1-bit registers (self-inverse)
    function automatic logic [31:0] lane_swap(input logic [31:0] v, input logic rev);
        if (rev) return v;
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

    // bit position of a line's 2-bit mode field within the 64-bit mode pair
    function automatic logic [5:0] mode_bit_pos(input int line, input logic rev);
        int p;
        int k;
        p = line / PORT_W;
        k = line % PORT_W;
        if (rev) return 6'(2 * line);
        return 6'(2 * (PORT_W * (p ^ 1) + k));
    endfunction

    function automatic logic [31:0] lines_mask(input int n);
        if (n >= MAX_LINES) return '1;
        return (32'd1 << n) - 32'd1;
    endfunction

endpackage

// File: rtl/gpio_line_edge.sv
module gpio_line_edge
    import gpio_bank_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_async,
    input  edge_mode_e mode,
    output logic       level,
    output logic       event_o
);

    logic meta_q;
    logic sync_q;
    logic prev_q;
    logic rise;
    logic fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= pin_async;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign rise  = sync_q & ~prev_q;
    assign fall  = ~sync_q & prev_q;
    assign level = sync_q;

    always_comb begin
        unique case (mode)
            MODE_OFF:  event_o = 1'b0;
            MODE_FALL: event_o = fall;
            MODE_RISE: event_o = rise;
            MODE_BOTH: event_o = rise | fall;
            default:   event_o = 1'b0;
        endcase
    end

    // an event needs the synchronised level to have just moved
    assert_edge_needs_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
        event_o |-> (sync_q != prev_q));

    // a changed level must be the one the previous clock sampled from meta
    assert_sync_chain_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (sync_q == $past(meta_q)));

endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status
    import gpio_bank_pkg::*;
#(
    parameter int          NUM_CPUS  = 2,
    parameter logic [31:0] IMPL_MASK = '1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [31:0]                  evt_i,
    input  logic                         clr_we,
    input  logic [31:0]                  clr_bits,
    input  logic [NUM_CPUS-1:0]          en_we,
    input  logic [31:0]                  en_bits,
    output logic [31:0]                  status_q,
    output logic [NUM_CPUS-1:0][31:0]    en_q,
    output logic                         irq,
    output logic [NUM_CPUS-1:0]          cpu_irq
);

    logic [31:0] clr_mask;
    logic [31:0] status_d;

    assign clr_mask = clr_we ? clr_bits : 32'd0;
    // a fresh event overrides a clear of the same bit
    assign status_d = ((status_q & ~clr_mask) | evt_i) & IMPL_MASK;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_q <= 32'd0;
        else        status_q <= status_d;
    end

    generate
        for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)       en_q[c] <= IMPL_MASK;
                else if (en_we[c]) en_q[c] <= en_bits & IMPL_MASK;
            end
            assign cpu_irq[c] = |(status_q & en_q[c]);
        end
    endgenerate

    assign irq = |status_q;

    assert_set_needs_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & ~$past(status_q) & ~$past(evt_i)) == 32'd0));

    assert_w1c_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & $past(clr_mask) & ~$past(evt_i)) == 32'd0));

    assert_event_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & $past(evt_i & IMPL_MASK)) == $past(evt_i & IMPL_MASK)));

    assert_cpu_implies_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|cpu_irq) |-> irq);

endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
    import gpio_bank_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int NUM_CPUS  = 2,
    parameter bit REVERSED  = 1'b0,
    parameter int ADDR_W    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [31:0]         pin_in,
    output logic [31:0]         pin_out,
    output logic [31:0]         pin_oe,
    output logic [31:0]         pin_func,
    output logic                irq,
    output logic [NUM_CPUS-1:0] cpu_irq
);

    localparam logic [31:0] IMPL     = lines_mask(NUM_LINES);
    localparam logic        REV      = REVERSED;
    localparam logic [31:0] IMPL_BUS = lane_swap(IMPL, REV);

    logic hit_func, hit_dir, hit_data, hit_stat, hit_mlo, hit_mhi, hit_1bit;
    logic [NUM_CPUS-1:0] hit_cpu;

    assign hit_func = bus_addr == ADDR_W'(OFS_FUNC);
    assign hit_dir  = bus_addr == ADDR_W'(OFS_DIR);
    assign hit_data = bus_addr == ADDR_W'(OFS_DATA);
    assign hit_stat = bus_addr == ADDR_W'(OFS_STAT);
    assign hit_mlo  = bus_addr == ADDR_W'(OFS_MODE_LO);
    assign hit_mhi  = bus_addr == ADDR_W'(OFS_MODE_HI);
    assign hit_1bit = hit_func | hit_dir | hit_data | hit_stat | (|hit_cpu);

    generate
        for (genvar c = 0; c < NUM_CPUS; c++) begin : g_hit
            assign hit_cpu[c] = bus_addr == ADDR_W'(OFS_CPU_BASE + CPU_STRIDE * c);
        end
    endgenerate

    logic [31:0] wr_line;
    assign wr_line = lane_swap(bus_wdata, REV) & IMPL;

    logic [31:0] func_q, dir_q, data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            func_q <= 32'd0;
            dir_q  <= 32'd0;
            data_q <= 32'd0;
        end else if (bus_we) begin
            if (hit_func) func_q <= wr_line;
            if (hit_dir)  dir_q  <= wr_line;
            if (hit_data) data_q <= wr_line;
        end
    end

    logic [31:0] lvl;
    logic [31:0] evt;
    logic [63:0] mode_rd;

    generate
        for (genvar n = 0; n < MAX_LINES; n++) begin : g_line
            localparam logic [5:0] POS = mode_bit_pos(n, REV);
            if (n < NUM_LINES) begin : g_on
                logic [1:0] mode_q;
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        mode_q <= 2'd0;
                    end else if (bus_we) begin
                        if (hit_mlo && !POS[5]) mode_q <= bus_wdata[POS[4:0] +: 2];
                        if (hit_mhi &&  POS[5]) mode_q <= bus_wdata[POS[4:0] +: 2];
                    end
                end
                assign mode_rd[POS +: 2] = mode_q;
                gpio_line_edge u_edge (
                    .clk      (clk),
                    .rst_n    (rst_n),
                    .pin_async(pin_in[n]),
                    .mode     (edge_mode_e'(mode_q)),
                    .level    (lvl[n]),
                    .event_o  (evt[n])
                );
            end else begin : g_off
                assign mode_rd[POS +: 2] = 2'd0;
                assign lvl[n] = 1'b0;
                assign evt[n] = 1'b0;
            end
        end
    endgenerate

    logic [31:0]                status_q;
    logic [NUM_CPUS-1:0][31:0]  en_q;
    logic [NUM_CPUS-1:0]        en_we;

    assign en_we = bus_we ? hit_cpu : '0;

    gpio_irq_status #(
        .NUM_CPUS (NUM_CPUS),
        .IMPL_MASK(IMPL)
    ) u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_i   (evt),
        .clr_we  (bus_we & hit_stat),
        .clr_bits(wr_line),
        .en_we   (en_we),
        .en_bits (wr_line),
        .status_q(status_q),
        .en_q    (en_q),
        .irq     (irq),
        .cpu_irq (cpu_irq)
    );

    logic [31:0] data_rd;
    assign data_rd = ((dir_q & data_q) | (~dir_q & lvl)) & IMPL;

    always_comb begin
        bus_rdata = 32'd0;
        if (hit_func) bus_rdata = lane_swap(func_q, REV);
        if (hit_dir)  bus_rdata = lane_swap(dir_q, REV);
        if (hit_data) bus_rdata = lane_swap(data_rd, REV);
        if (hit_stat) bus_rdata = lane_swap(status_q, REV);
        if (hit_mlo)  bus_rdata = mode_rd[31:0];
        if (hit_mhi)  bus_rdata = mode_rd[63:32];
        for (int c = 0; c < NUM_CPUS; c++) begin
            if (hit_cpu[c]) bus_rdata = lane_swap(en_q[c], REV);
        end
    end

    assign pin_out  = data_q;
    assign pin_oe   = dir_q;
    assign pin_func = func_q;

    // output lines read back what they drive
    assert_out_readback_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hit_data |-> (((bus_rdata ^ lane_swap(pin_out, REV)) & lane_swap(pin_oe, REV)) == 32'd0));

    assert_unimpl_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hit_1bit |-> ((bus_rdata & ~IMPL_BUS) == 32'd0));

endmodule

// File: tb/tb_gpio_edge_bank.sv
module tb_gpio_edge_bank;

    localparam int NC = 2;
    localparam logic [31:0] MN = 32'h0FFF_FFFF;  // 28-line instance
    localparam logic [31:0] MR = 32'hFFFF_FFFF;  // 32-line instance

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] addr = 8'h04;
    logic we = 1'b0;
    logic [31:0] wd_n = '0, wd_r = '0, rd_n, rd_r;
    logic [31:0] pins = '0;
    logic [31:0] po_n, oe_n, pf_n, po_r, oe_r, pf_r;
    logic irq_n, irq_r;
    logic [NC-1:0] ci_n, ci_r;

    always #5 clk = ~clk;

    gpio_edge_bank #(.NUM_LINES(28), .NUM_CPUS(NC), .REVERSED(1'b0), .ADDR_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wd_n),
        .bus_rdata(rd_n), .pin_in(pins), .pin_out(po_n), .pin_oe(oe_n), .pin_func(pf_n),
        .irq(irq_n), .cpu_irq(ci_n));

    gpio_edge_bank #(.NUM_LINES(32), .NUM_CPUS(NC), .REVERSED(1'b1), .ADDR_W(8)) dut_rev (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wd_r),
        .bus_rdata(rd_r), .pin_in(pins), .pin_out(po_r), .pin_oe(oe_r), .pin_func(pf_r),
        .irq(irq_r), .cpu_irq(ci_r));

    int n_tests = 0;
    int n_fail = 0;

    logic [1:0]  m_mode [32];
    logic [31:0] m_stat = '0, m_pin = '0, m_dir = '0, m_data = '0, m_func = '0;
    logic [31:0] m_en [NC];

    function automatic logic [31:0] pk1(input logic [31:0] v, input bit rev);
        logic [31:0] r = '0;
        for (int n = 0; n < 32; n++) begin
            int p = n / 8;
            int k = n % 8;
            int pos = rev ? n : 8 * (3 - p) + k;
            r[pos] = v[n];
        end
        return r;
    endfunction

    function automatic logic [31:0] pkm(input int word, input bit rev, input logic [31:0] msk);
        logic [31:0] r = '0;
        for (int n = 0; n < 32; n++) begin
            int p = n / 8;
            int k = n % 8;
            int pos = rev ? 2 * n : 2 * (8 * (p ^ 1) + k);
            if (msk[n] && (pos / 32 == word)) r[pos % 32 +: 2] = m_mode[n];
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr1(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk);
        addr = a; we = 1'b1; wd_n = pk1(v, 0); wd_r = pk1(v, 1);
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic wrmode(input int word);
        @(negedge clk);
        addr = word == 0 ? 8'h14 : 8'h18; we = 1'b1;
        wd_n = pkm(word, 0, '1); wd_r = pkm(word, 1, '1);
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd1(input string tag, input logic [7:0] a, input logic [31:0] v);
        @(negedge clk);
        addr = a;
        #1;
        check({tag, " normal"}, rd_n, pk1(v & MN, 0));
        check({tag, " reversed"}, rd_r, pk1(v & MR, 1));
    endtask

    task automatic rdmode(input string tag);
        for (int w = 0; w < 2; w++) begin
            @(negedge clk);
            addr = w == 0 ? 8'h14 : 8'h18;
            #1;
            check({tag, " normal"}, rd_n, pkm(w, 0, MN));
            check({tag, " reversed"}, rd_r, pkm(w, 1, MR));
        end
    endtask

    task automatic drive_pins(input logic [31:0] nv);
        logic [31:0] rise, fall;
        rise = nv & ~m_pin;
        fall = ~nv & m_pin;
        for (int n = 0; n < 32; n++)
            if ((m_mode[n][1] && rise[n]) || (m_mode[n][0] && fall[n])) m_stat[n] = 1'b1;
        m_pin = nv;
        @(negedge clk);
        pins = nv;
        repeat (4) @(negedge clk);
    endtask

    task automatic check_irqs(input string tag);
        #1;
        check({tag, " irq normal"}, {31'd0, irq_n}, {31'd0, |(m_stat & MN)});
        check({tag, " irq reversed"}, {31'd0, irq_r}, {31'd0, |m_stat});
        for (int c = 0; c < NC; c++) begin
            check({tag, " cpu_irq normal"}, {31'd0, ci_n[c]}, {31'd0, |(m_stat & m_en[c] & MN)});
            check({tag, " cpu_irq reversed"}, {31'd0, ci_r[c]}, {31'd0, |(m_stat & m_en[c])});
        end
    endtask

    initial begin
        for (int n = 0; n < 32; n++) m_mode[n] = 2'd0;
        for (int c = 0; c < NC; c++) m_en[c] = '1;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: reset state
        rd1("R1 func", 8'h00, '0);
        rd1("R1 dir", 8'h08, '0);
        rd1("R1 data", 8'h0C, '0);
        rd1("R1 status", 8'h10, '0);
        rdmode("R1 mode");
        rd1("R1 cpu0 enable", 8'h20, '1);
        rd1("R1 cpu1 enable", 8'h24, '1);
        check_irqs("R1");

        // R2: unmapped addresses read zero and ignore writes
        wr1(8'h04, '1);
        wr1(8'h1C, '1);
        rd1("R2 hole 0x04", 8'h04, '0);
        rd1("R2 hole 0x1C", 8'h1C, '0);
        rd1("R2 dir untouched", 8'h08, '0);

        // R3 / R11: 1-bit packing, function select outputs
        m_func = 32'h8421_0F3C;
        wr1(8'h00, m_func);
        rd1("R3 func packing", 8'h00, m_func);
        check("R11 pin_func normal", pf_n, m_func & MN);
        check("R11 pin_func reversed", pf_r, m_func);

        // R4: single-line mode positions
        m_mode[0] = 2'd1; m_mode[9] = 2'd2; m_mode[18] = 2'd3; m_mode[27] = 2'd1; m_mode[31] = 2'd3;
        wrmode(0); wrmode(1);
        rdmode("R4 mode placement");

        // random phase
        for (int it = 0; it < 80; it++) begin
            for (int n = 0; n < 32; n++) m_mode[n] = 2'($urandom % 4);
            wrmode(0); wrmode(1);
            if (it % 8 == 0) rdmode("R4 random modes");
            for (int c = 0; c < NC; c++) begin
                m_en[c] = $urandom;
                wr1(8'(8'h20 + 4 * c), m_en[c]);
            end
            m_dir = $urandom; m_data = $urandom;
            wr1(8'h08, m_dir); wr1(8'h0C, m_data);
            drive_pins($urandom);
            rd1("R5 status after edges", 8'h10, m_stat);
            check_irqs("R10");
            rd1("R8 data readback", 8'h0C, (m_dir & m_data) | (~m_dir & m_pin));
            check("R8 pin_oe", oe_n, m_dir & MN);
            check("R8 pin_out", po_r, m_data);
            if (it % 2 == 1) begin
                logic [31:0] w;
                w = $urandom;
                wr1(8'h10, w);
                m_stat = m_stat & ~w;
                rd1("R6 after clear", 8'h10, m_stat);
                check_irqs("R6 R10");
            end
        end

        // R6: clear everything, then writing zero has no effect
        wr1(8'h10, '1);
        m_stat = '0;
        for (int n = 0; n < 32; n++) m_mode[n] = 2'd3;
        wrmode(0); wrmode(1);
        for (int c = 0; c < NC; c++) begin
            m_en[c] = '1;
            wr1(8'(8'h20 + 4 * c), '1);
        end
        drive_pins(m_pin ^ 32'h0000_00F0);
        wr1(8'h10, 32'h0);
        rd1("R6 write zero keeps bits", 8'h10, m_stat);

        // R9: lines 28..31 toggle in both-edge mode
        wr1(8'h10, '1);
        m_stat = '0;
        drive_pins(m_pin ^ 32'hF000_0000);
        rd1("R9 upper lines", 8'h10, m_stat);
        check_irqs("R9");

        // R7: event and clear land in the same cycle
        wr1(8'h10, '1);
        m_stat = '0;
        for (int n = 0; n < 32; n++) m_mode[n] = 2'd2;
        wrmode(0); wrmode(1);
        drive_pins(32'h0);
        wr1(8'h10, '1);
        m_stat = '0;
        @(negedge clk);
        pins = 32'h0000_0008;
        m_pin = 32'h0000_0008;
        @(negedge clk);
        @(negedge clk);
        addr = 8'h10; we = 1'b1; wd_n = pk1(32'h8, 0); wd_r = pk1(32'h8, 1);
        @(negedge clk);
        we = 1'b0;
        m_stat = 32'h8;
        rd1("R7 event beats clear", 8'h10, m_stat);
        wr1(8'h10, 32'h8);
        m_stat = '0;
        rd1("R6 bit then clears", 8'h10, m_stat);
        check_irqs("R7 R10");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule